// File: doc/BRIEF.md
# Divider Configuration Port for a Clock Synthesizer

This block holds the settings that a frequency synthesizer's dividers run from: a 9-bit feedback divide value, a 2-bit output-divider code and a 3-bit test-mode select. Two load paths share these registers. The first is a set of parallel pins gated by an active-low strobe. While the strobe is low, the pins pass straight through to the registers. The value on the pins is captured when the strobe rises. The second is a three-wire serial port with data, clock and load lines. A 14-bit shift register collects the bits. A rising edge on the load line moves its contents into the registers. While the load line stays high, every serial clock edge updates the registers, and the contents are frozen once the load line falls.

All strobe and data pins are brought into one configuration clock domain through synchronisers. Edges are detected there, so each change on a pin takes effect on the third rising edge of `clk` after it. The most significant bit of the shift register drives a dedicated output that serves as the serial-out choice of the test pin.

Top module: `cfg_divider_if`

## Requirements
- R1: After reset, `m_div` is 9'h1FF, `n_code` is 2'b11, `test_sel` is 3'b000 and `shift_out` is 0.
- R2: While `par_load_n` is low, `m_div` and `n_code` follow `par_m` and `par_n`, and `test_sel` is 3'b000. A pin change appears on the third `clk` rising edge after it.
- R3: After `par_load_n` rises, the registers keep the value last seen on the pins, and later pin changes have no effect.
- R4: While `par_load_n` is high, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the shift register. `shift_out` is bit 13, the oldest bit held.
- R5: The serial frame is 14 bits sent in this order: test bits 2..0, then N bits 1..0, then M bits 8..0, with M bit 0 sent last. After a full frame, register bits [13:11] hold the test select, bits [10:9] hold N and bits [8:0] hold M.
- R6: A rising edge on `ser_load` (with `par_load_n` high) copies the shift register into `test_sel`, `n_code` and `m_div`.
- R7: While `ser_load` is low, serial shifting leaves the outputs unchanged. After `ser_load` falls, the outputs hold the last value they took.
- R8: While `ser_load` is held high, every rising edge of `ser_clk` updates the outputs with the new shift register contents.
- R9: A serial transfer replaces a value captured from the parallel pins, including a nonzero test select. Only the serial path can set `test_sel` to a value other than 000.
- R10: If a `ser_load` rising edge and a `ser_clk` rising edge fall in the same `clk` cycle, the transferred value includes the bit shifted on that edge.
- R11: While `par_load_n` is low, `ser_clk` edges do not shift the register, and `ser_load` does not alter the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Active-low parallel load strobe |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output-divider code |
| ser_clk | input | 1 | Serial shift clock, sampled in `clk` domain |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load strobe |
| m_div | output | 9 | Feedback divide register |
| n_code | output | 2 | Output-divider code register |
| test_sel | output | 3 | Test-mode select register |
| shift_out | output | 1 | Oldest bit of the shift register |

## Verification
A serial shift and a serial transfer can both happen in one `clk` cycle. This occurs when the load line and the serial clock rise together and land in the same synchronised cycle. The bench provokes this by raising both lines at the same instant after 13 bits of a frame, with the last bit already on the data line. It then judges the case by comparing the outputs with the complete 14-bit frame, not with the 13-bit prefix. A second overlap, the parallel strobe held low while serial edges arrive, is judged through `shift_out` and the outputs once the strobe is raised again.

// File: rtl/cfg_div_pkg.sv
package cfg_div_pkg;
  // Positions of the strobe lines in the synchronised strobe vector
  localparam int SIDX_PAR = 0;
  localparam int SIDX_SCK = 1;
  localparam int SIDX_SLD = 2;
  localparam int NSTROBE  = 3;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt,
  output logic         sout
);
  logic [W-1:0] sh_q;

  always_comb begin
    q_nxt = sh_q;
    if (en) q_nxt = {sh_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= q_nxt;
  end

  assign q    = sh_q;
  assign sout = sh_q[W-1];

  assert_shift_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (sh_q[0] == $past(din)));
  assert_shift_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sh_q));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
  parameter int           W        = 14,
  parameter logic [W-1:0] RST_WORD = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         par_low,
  input  logic [W-1:0] par_word,
  input  logic         ser_upd,
  input  logic [W-1:0] ser_word,
  output logic [W-1:0] word_q
);
  logic [W-1:0] word_nxt;

  always_comb begin
    word_nxt = word_q;
    if (par_low)      word_nxt = par_word;
    else if (ser_upd) word_nxt = ser_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= RST_WORD;
    else        word_q <= word_nxt;
  end

  assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    par_low |=> (word_q == $past(par_word)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_low && !ser_upd) |=> $stable(word_q));
  assert_ser_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_low && ser_upd) |=> (word_q == $past(ser_word)));
endmodule

// File: rtl/cfg_divider_if.sv
module cfg_divider_if
  import cfg_div_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 2,
  parameter int T_W         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] m_div,
  output logic [N_W-1:0] n_code,
  output logic [T_W-1:0] test_sel,
  output logic           shift_out
);
  localparam int PIN_W   = M_W + N_W;
  localparam int FRAME_W = PIN_W + T_W;
  localparam int BUS_W   = NSTROBE + 1 + PIN_W;
  localparam logic [NSTROBE-1:0] STRB_RST = NSTROBE'(1 << SIDX_PAR);
  localparam logic [BUS_W-1:0]   BUS_RST  = {STRB_RST, 1'b0, {PIN_W{1'b1}}};
  localparam logic [FRAME_W-1:0] WORD_RST = {{T_W{1'b0}}, {PIN_W{1'b1}}};

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // Bring every pin into the clk domain with equal latency
  logic [BUS_W-1:0]   bus_raw, bus_s;
  logic [NSTROBE-1:0] strb_raw, strb_s;
  logic               data_s;
  logic [PIN_W-1:0]   pins_s;

  always_comb begin
    strb_raw           = '0;
    strb_raw[SIDX_PAR] = par_load_n;
    strb_raw[SIDX_SCK] = ser_clk;
    strb_raw[SIDX_SLD] = ser_load;
  end

  assign bus_raw = {strb_raw, ser_data, par_n, par_m};

  cfg_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) i_sync (
    .clk(clk), .rst_n(rst_n_s), .d(bus_raw), .q(bus_s)
  );

  assign strb_s = bus_s[BUS_W-1 -: NSTROBE];
  assign data_s = bus_s[PIN_W];
  assign pins_s = bus_s[PIN_W-1:0];

  // Rising edges of serial clock (bit 0) and serial load (bit 1)
  logic [1:0] ser_rise;

  cfg_edge #(.W(2), .RST_VAL(2'b00)) i_edge (
    .clk(clk), .rst_n(rst_n_s),
    .lvl({strb_s[SIDX_SLD], strb_s[SIDX_SCK]}),
    .rise(ser_rise)
  );

  logic par_low, clk_rise, load_rise, shift_en, ser_upd;

  assign par_low   = ~strb_s[SIDX_PAR];
  assign clk_rise  = ser_rise[0];
  assign load_rise = ser_rise[1];
  assign shift_en  = ~par_low & clk_rise;
  // Transfer on load rise, or follow every shift while load is high
  assign ser_upd   = load_rise | (strb_s[SIDX_SLD] & clk_rise);

  logic [FRAME_W-1:0] sh_q, sh_nxt, word_q;

  cfg_shift #(.W(FRAME_W)) i_shift (
    .clk(clk), .rst_n(rst_n_s), .en(shift_en), .din(data_s),
    .q(sh_q), .q_nxt(sh_nxt), .sout(shift_out)
  );

  cfg_regs #(.W(FRAME_W), .RST_WORD(WORD_RST)) i_regs (
    .clk(clk), .rst_n(rst_n_s),
    .par_low(par_low), .par_word({{T_W{1'b0}}, pins_s}),
    .ser_upd(ser_upd), .ser_word(sh_nxt),
    .word_q(word_q)
  );

  assign test_sel = word_q[FRAME_W-1 -: T_W];
  assign n_code   = word_q[PIN_W-1 -: N_W];
  assign m_div    = word_q[M_W-1:0];

  assert_par_test_zero_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    par_low |=> (test_sel == '0));
  assert_out_is_msb_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    shift_en |=> (shift_out == $past(sh_q[FRAME_W-2])));
endmodule

// File: tb/test_cfg_divider_if.sv
module test_cfg_divider_if;
  localparam int CLK_P    = 10;
  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_load_n;
  logic [8:0] par_m;
  logic [1:0] par_n;
  logic       ser_clk, ser_data, ser_load;
  logic [8:0] m_div;
  logic [1:0] n_code;
  logic [2:0] test_sel;
  logic       shift_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [13:0] model_sh;
  logic [8:0]  exp_m;
  logic [1:0]  exp_n;
  logic [2:0]  exp_t;

  always #(CLK_P/2) clk = ~clk;

  cfg_divider_if i_cfg_divider_if (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m),
    .par_n(par_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .m_div(m_div), .n_code(n_code),
    .test_sel(test_sel), .shift_out(shift_out)
  );

  function automatic logic [13:0] make_frame(logic [2:0] t, logic [1:0] n, logic [8:0] m);
    return {t, n, m};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req);
    chk({req, " m"}, 32'(m_div), 32'(exp_m));
    chk({req, " n"}, 32'(n_code), 32'(exp_n));
    chk({req, " t"}, 32'(test_sel), 32'(exp_t));
  endtask

  task automatic take_model();
    exp_t = model_sh[13:11];
    exp_n = model_sh[10:9];
    exp_m = model_sh[8:0];
  endtask

  task automatic ser_bit(logic b);
    ser_data = b;
    tick(3);
    ser_clk = 1'b1;
    if (par_load_n) begin
      model_sh = {model_sh[12:0], b};
      if (ser_load) take_model();
    end
    tick(4);
    ser_clk = 1'b0;
    tick(4);
  endtask

  task automatic ser_frame(logic [13:0] f);
    for (int i = 13; i >= 0; i--) ser_bit(f[i]);
  endtask

  task automatic load_pulse();
    ser_load = 1'b1;
    tick(5);
    take_model();
    ser_load = 1'b0;
    tick(5);
  endtask

  task automatic par_apply(logic [8:0] m, logic [1:0] n);
    par_m = m;
    par_n = n;
    tick(5);
    exp_m = m;
    exp_n = n;
    exp_t = 3'b000;
  endtask

  initial begin
    for (int c = 0; c < WD_LIMIT; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=finish", WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [13:0] f;
    void'($urandom(32'd7131));
    rst_n = 1'b0; par_load_n = 1'b1; par_m = '0; par_n = '0;
    ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0;
    model_sh = '0;
    tick(3);
    rst_n = 1'b1;
    tick(6);
    // R1: reset state
    exp_m = 9'h1FF; exp_n = 2'b11; exp_t = 3'b000;
    chk_out("R1");
    chk("R1 shift_out", 32'(shift_out), 32'd0);

    // R2: parallel pass-through while strobe is low
    par_load_n = 1'b0;
    par_apply(9'h0A5, 2'b01);
    chk_out("R2 first");
    par_apply(9'h15A, 2'b10);
    chk_out("R2 second");
    // R3: capture on strobe rise, later pin changes ignored
    par_load_n = 1'b1;
    tick(5);
    par_m = 9'h003; par_n = 2'b00;
    tick(6);
    chk_out("R3 hold");

    // R5/R7: frame shifted with load low leaves outputs alone
    f = make_frame(3'b101, 2'b11, 9'h17D);
    ser_frame(f);
    chk_out("R7 no load");
    chk("R4 R5 msb after frame", 32'(shift_out), 32'(f[13]));
    // R6/R9: load rise replaces the parallel value, test bits included
    load_pulse();
    chk_out("R6 R9 transfer");
    chk("R5 fields", 32'({test_sel, n_code, m_div}), 32'(f));
    // R4: one more shift exposes the next oldest bit
    ser_bit(1'b0);
    chk("R4 shift_out", 32'(shift_out), 32'(f[12]));
    chk_out("R7 after extra bit");

    // R8: transparent mode while load is held high
    ser_load = 1'b1;
    tick(5);
    take_model();
    chk_out("R8 rise");
    for (int i = 0; i < 6; i++) begin
      ser_bit(1'($urandom_range(0, 1)));
      chk_out("R8 follow");
    end
    ser_load = 1'b0;
    tick(5);
    // R7: frozen after load falls
    ser_bit(1'b1);
    ser_bit(1'b0);
    chk_out("R7 frozen");

    // R11: strobe low blocks shifting and serial load
    par_load_n = 1'b0;
    par_apply(9'h0F0, 2'b00);
    chk_out("R2 test forced");
    for (int i = 0; i < 3; i++) ser_bit(~shift_out);
    ser_load = 1'b1; tick(5); ser_load = 1'b0; tick(5);
    chk_out("R11 outputs");
    chk("R11 shift_out", 32'(shift_out), 32'(model_sh[13]));
    par_load_n = 1'b1;
    tick(5);
    load_pulse();
    chk_out("R11 shift register unchanged");

    // R10: load rise and clock rise in the same cycle
    f = make_frame(3'b011, 2'b10, 9'h0C6);
    for (int i = 13; i >= 1; i--) ser_bit(f[i]);
    ser_data = f[0];
    tick(3);
    ser_clk = 1'b1;
    ser_load = 1'b1;
    model_sh = {model_sh[12:0], f[0]};
    tick(5);
    take_model();
    chk_out("R10 coincident");
    chk("R10 full frame", 32'({test_sel, n_code, m_div}), 32'(f));
    ser_clk = 1'b0;
    tick(4);
    ser_load = 1'b0;
    tick(5);

    // Random mix of serial frames and parallel captures
    for (int it = 0; it < 24; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        par_load_n = 1'b0;
        par_apply(9'($urandom_range(0, 511)), 2'($urandom_range(0, 3)));
        chk_out("R2 random");
        par_load_n = 1'b1;
        tick(5);
        par_m = 9'($urandom_range(0, 511));
        tick(5);
        chk_out("R3 random");
      end
      f = make_frame(3'($urandom_range(1, 7)), 2'($urandom_range(0, 3)),
                     9'($urandom_range(0, 511)));
      ser_frame(f);
      chk("R4 random msb", 32'(shift_out), 32'(f[13]));
      load_pulse();
      chk_out("R6 R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule